// File: doc/BRIEF.md
# Overlap-Aware Storage Move Sequencer

This block copies 1 to 256 bytes from one place in a byte-addressed memory to another. The result is always the same as a plain copy that moves one byte at a time from the lowest address upward, even when the two operands overlap. A request gives a source address, a destination address and a length. The block sorts the request into one of five execution classes and then runs the memory reads and writes for that class. It reports the class and pulses `done` when the copy has finished.

The memory port has separate read and write addresses. Each access is up to 8 bytes wide, and lane i of the data bus belongs to byte address base+i. Read data comes back in the same cycle as the read request. A write takes effect at the clock edge. Operands that do not overlap are moved up to 8 bytes per beat. A short move loads all of its source bytes into a buffer first and stores them afterwards. Two overlap patterns are common: destination one byte above the source, and destination eight bytes above the source. Both are turned into pattern fills. Any other destructive overlap falls back to a one-byte-per-cycle copy.

The controller has eight states:
- IDLE waits for `start`, latches the request and picks the next state from the class.
- SLOAD reads beats into the buffer. It moves to SSTORE after the last beat.
- SSTORE writes beats out of the buffer. It moves to FINISH after the last beat.
- LCOPY reads and writes one beat per cycle. It moves to FINISH after the last beat.
- PFETCH reads the 8-byte pattern once and always moves to PFILL.
- PFILL writes the pattern beat by beat. It moves to FINISH after the last beat.
- BCOPY copies one byte per cycle. It moves to FINISH after the last byte.
- FINISH asserts `done` for one cycle and returns to IDLE.

Top module: `mv_move_seq`

## Requirements
- R1: Let L = len_m1 + 1. The operands overlap when dst > src and dst < src + L. A move with no overlap is class 0 (short) when L <= 16 and class 1 (long) otherwise. A destination equal to the source, or equal to src + L, counts as no overlap.
- R2: When the operands overlap and dst = src + 1, the class is 2. Every destination byte then receives the original byte at src.
- R3: When the operands overlap and dst = src + 8, the class is 3. Destination byte k then receives the original byte at src + (k mod 8).
- R4: Any other overlap is class 4. It issues exactly L writes, in ascending address order, each with only byte enable bit 0 set.
- R5: For every class, the memory image after `done` equals the image a byte-serial ascending copy would leave. Bytes outside the destination are unchanged.
- R6: A short move issues ceil(L/8) reads and then ceil(L/8) writes. No read occurs once writing has begun.
- R7: A long move issues ceil(L/8) beats, each reading and writing in the same cycle. Its byte enables always start at lane 0 and are contiguous.
- R8: A fill move (class 2 or 3) issues exactly one read, then ceil(L/8) writes with no further reads.
- R9: `busy` rises in the cycle after `start` is seen in idle. `move_class` holds steady while busy. `done` is a single-cycle pulse that comes one cycle after the last write. `busy` is low in the cycle after `done`.
- R10: `len_m1` encodes L - 1, so 0 means 1 byte and 255 means 256 bytes.
- R11: After reset and while idle, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request strobe, sampled in idle only |
| src_addr | input | AW | Source start byte address |
| dst_addr | input | AW | Destination start byte address |
| len_m1 | input | LW | Length minus one |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| move_class | output | 3 | 0 short, 1 long, 2 fill1, 3 fill8, 4 bytewise |
| mem_rd_en | output | 1 | Read request |
| mem_rd_addr | output | AW | Read base byte address |
| mem_rd_data | input | 64 | Read data, lane i from base+i |
| mem_wr_en | output | 1 | Write request |
| mem_wr_addr | output | AW | Write base byte address |
| mem_wr_data | output | 64 | Write data, lane i to base+i |
| mem_wr_be | output | 8 | Per-lane write enables |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit length code and a short-move limit of 16 bytes. With these values, both sides of the 16/17-byte class boundary can be tested, as can the 256-byte maximum length (code 255) and the 1-byte minimum (code 0). The 16-bit address range leaves room for operands that overlap downward, sit exactly adjacent to each other, or coincide. For every move, a scoreboard checks the class, the number of reads and writes, and the whole memory image.

// File: rtl/mv_pkg.sv
package mv_pkg;
    localparam int LANES = 8;

    typedef enum logic [2:0] {
        MC_SHORT = 3'd0,
        MC_LONG  = 3'd1,
        MC_FILL1 = 3'd2,
        MC_FILL8 = 3'd3,
        MC_BYTE  = 3'd4
    } mv_class_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SLOAD, S_SSTORE, S_LCOPY, S_PFETCH, S_PFILL, S_BCOPY, S_FINISH
    } mv_state_e;
endpackage

// File: rtl/mv_classify.sv
module mv_classify
    import mv_pkg::*;
#(
    parameter int AW        = 16,
    parameter int LW        = 8,
    parameter int SHORT_MAX = 16
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [LW-1:0] len_m1,
    output mv_class_e     cls
);
    logic [AW:0] s_ext, d_ext, s_end, s_p1, s_p8;
    logic        overlap;

    always_comb begin
        s_ext   = {1'b0, src};
        d_ext   = {1'b0, dst};
        s_end   = s_ext + {{(AW+1-LW){1'b0}}, len_m1} + (AW+1)'(1);
        s_p1    = s_ext + (AW+1)'(1);
        s_p8    = s_ext + (AW+1)'(LANES);
        overlap = (d_ext > s_ext) && (d_ext < s_end);
        if (overlap) begin
            if (d_ext == s_p1)      cls = MC_FILL1;
            else if (d_ext == s_p8) cls = MC_FILL8;
            else                    cls = MC_BYTE;
        end else if (int'(len_m1) < SHORT_MAX) begin
            cls = MC_SHORT;
        end else begin
            cls = MC_LONG;
        end
    end
endmodule

// File: rtl/mv_lane_mask.sv
module mv_lane_mask #(
    parameter int CW    = 9,
    parameter int LANES = 8
) (
    input  logic [CW-1:0]    rem_bytes,
    output logic [LANES-1:0] be
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be[i] = rem_bytes > CW'(i);
    end
endmodule

// File: rtl/mv_move_seq.sv
module mv_move_seq
    import mv_pkg::*;
#(
    parameter int AW        = 16,
    parameter int LW        = 8,
    parameter int SHORT_MAX = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [LW-1:0] len_m1,
    output logic          busy,
    output logic          done,
    output logic [2:0]    move_class,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [63:0]   mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [63:0]   mem_wr_data,
    output logic [7:0]    mem_wr_be
);
    localparam int CW          = LW + 1;
    localparam int DW          = LANES * 8;
    localparam int LB          = $clog2(LANES);
    localparam int SHORT_BEATS = SHORT_MAX / LANES;
    localparam int SB_IW       = $clog2(SHORT_BEATS);

    mv_state_e       state_q, state_d;
    mv_class_e       cls_w, cls_q;
    logic [AW-1:0]   src_q, dst_q;
    logic [CW-1:0]   total_q, off_q, rem_w;
    logic [DW-1:0]   pat_q;
    logic [DW-1:0]   sbuf_q [SHORT_BEATS];
    logic [SB_IW-1:0] beat_idx;
    logic [CW:0]     off_beat, off_byte;
    logic            last_beat, last_byte;
    logic [LANES-1:0] mask_w;
    logic [AW-1:0]   off_ext;

    mv_classify #(.AW(AW), .LW(LW), .SHORT_MAX(SHORT_MAX)) u_cls (
        .src(src_addr), .dst(dst_addr), .len_m1(len_m1), .cls(cls_w)
    );

    assign rem_w = total_q - off_q;

    mv_lane_mask #(.CW(CW), .LANES(LANES)) u_mask (
        .rem_bytes(rem_w), .be(mask_w)
    );

    assign off_beat  = {1'b0, off_q} + (CW+1)'(LANES);
    assign off_byte  = {1'b0, off_q} + (CW+1)'(1);
    assign last_beat = off_beat >= {1'b0, total_q};
    assign last_byte = off_byte >= {1'b0, total_q};
    assign beat_idx  = off_q[LB +: SB_IW];
    assign off_ext   = {{(AW-CW){1'b0}}, off_q};

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cls_q   <= MC_SHORT;
            src_q   <= '0;
            dst_q   <= '0;
            total_q <= '0;
            off_q   <= '0;
            pat_q   <= '0;
            for (int b = 0; b < SHORT_BEATS; b++) sbuf_q[b] <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: if (start) begin
                    src_q   <= src_addr;
                    dst_q   <= dst_addr;
                    total_q <= {1'b0, len_m1} + CW'(1);
                    off_q   <= '0;
                    cls_q   <= cls_w;
                end
                S_SLOAD: begin
                    sbuf_q[beat_idx] <= mem_rd_data;
                    off_q <= last_beat ? '0 : off_beat[CW-1:0];
                end
                S_SSTORE, S_LCOPY, S_PFILL: off_q <= off_beat[CW-1:0];
                S_PFETCH: pat_q <= (cls_q == MC_FILL1) ? {LANES{mem_rd_data[7:0]}}
                                                       : mem_rd_data;
                S_BCOPY:  off_q <= off_byte[CW-1:0];
                S_FINISH: off_q <= '0;
                default:  ;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) begin
                unique case (cls_w)
                    MC_SHORT:          state_d = S_SLOAD;
                    MC_LONG:           state_d = S_LCOPY;
                    MC_FILL1, MC_FILL8: state_d = S_PFETCH;
                    default:           state_d = S_BCOPY;
                endcase
            end
            S_SLOAD:  if (last_beat) state_d = S_SSTORE;
            S_SSTORE: if (last_beat) state_d = S_FINISH;
            S_LCOPY:  if (last_beat) state_d = S_FINISH;
            S_PFETCH: state_d = S_PFILL;
            S_PFILL:  if (last_beat) state_d = S_FINISH;
            S_BCOPY:  if (last_byte) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy        = state_q != S_IDLE;
        done        = state_q == S_FINISH;
        move_class  = cls_q;
        mem_rd_en   = 1'b0;
        mem_wr_en   = 1'b0;
        mem_rd_addr = src_q + off_ext;
        mem_wr_addr = dst_q + off_ext;
        mem_wr_data = mem_rd_data;
        mem_wr_be   = mask_w;
        unique case (state_q)
            S_SLOAD:  mem_rd_en = 1'b1;
            S_SSTORE: begin
                mem_wr_en   = 1'b1;
                mem_wr_data = sbuf_q[beat_idx];
            end
            S_LCOPY: begin
                mem_rd_en = 1'b1;
                mem_wr_en = 1'b1;
            end
            S_PFETCH: mem_rd_en = 1'b1;
            S_PFILL: begin
                mem_wr_en   = 1'b1;
                mem_wr_data = pat_q;
            end
            S_BCOPY: begin
                mem_rd_en = 1'b1;
                mem_wr_en = 1'b1;
                mem_wr_be = {{(LANES-1){1'b0}}, 1'b1};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mv_move_seq_chk.sv
module mv_move_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] move_class,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic [7:0] mem_wr_be
);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_wr_en && !mem_rd_en && !done));

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_class_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(move_class));

    p_byte_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && move_class == 3'd4) |-> (mem_wr_be == 8'h01));

    p_be_contig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_be[0] && $onehot0({1'b0, mem_wr_be} + 9'd1)));

    p_fill_noread_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && (move_class == 3'd2 || move_class == 3'd3)) |-> !mem_rd_en);

    p_short_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && move_class == 3'd0) |-> !mem_rd_en);
endmodule

bind mv_move_seq mv_move_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .move_class(move_class), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wr_be(mem_wr_be)
);

// File: tb/mv_move_seq_bench.sv
`timescale 1ns/1ps
module mv_move_seq_bench;
    localparam int AW = 16;
    localparam int LW = 8;
    localparam int MSZ = 1024;

    typedef struct {
        int    cls;
        int    wr;
        int    rd;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_addr = '0, dst_addr = '0;
    logic [LW-1:0] len_m1 = '0;
    logic          busy, done, mem_rd_en, mem_wr_en;
    logic [2:0]    move_class;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [63:0]   mem_rd_data, mem_wr_data;
    logic [7:0]    mem_wr_be;

    logic [7:0] mem     [MSZ];
    logic [7:0] ref_mem [MSZ];
    exp_t       sb_q [$];
    int n_checks = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0, cyc = 0;

    always #2.5 clk = ~clk;

    mv_move_seq #(.AW(AW), .LW(LW), .SHORT_MAX(16)) u_mv_move_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
        .dst_addr(dst_addr), .len_m1(len_m1), .busy(busy), .done(done),
        .move_class(move_class), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
    );

    always_comb
        for (int i = 0; i < 8; i++)
            mem_rd_data[8*i +: 8] = mem[(int'(mem_rd_addr) + i) % MSZ];

    always @(posedge clk)
        if (mem_wr_en)
            for (int i = 0; i < 8; i++)
                if (mem_wr_be[i]) mem[(int'(mem_wr_addr) + i) % MSZ] <= mem_wr_data[8*i +: 8];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // monitor: counts port activity and scores each completed move
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
        if (rst_n) begin
            if (mem_wr_en) wr_cnt++;
            if (mem_rd_en) rd_cnt++;
            if (done) begin
                exp_t e;
                int bad;
                string ct;
                e = sb_q.pop_front();
                chk(int'(move_class) == e.cls, "R1", "class", int'(move_class), e.cls);
                case (e.cls)
                    0: ct = "R6";
                    1: ct = "R7";
                    4: ct = "R4";
                    default: ct = "R8";
                endcase
                chk(wr_cnt == e.wr, ct, "write count", wr_cnt, e.wr);
                chk(rd_cnt == e.rd, ct, "read count", rd_cnt, e.rd);
                bad = 0;
                for (int a = 0; a < MSZ; a++) if (mem[a] !== ref_mem[a]) bad++;
                chk(bad == 0, {"R5 ", e.tag}, "mismatched bytes", bad, 0);
                wr_cnt = 0;
                rd_cnt = 0;
            end
        end
    end

    // driver: builds the byte-serial reference, queues expectations, issues the move
    task automatic run_move(input int s, input int d, input int len, input int cls,
                            input string tag);
        exp_t e;
        int beats;
        beats = (len + 7) / 8;
        for (int a = 0; a < MSZ; a++) ref_mem[a] = mem[a];
        for (int k = 0; k < len; k++) ref_mem[d + k] = ref_mem[s + k];
        e.cls = cls;
        e.tag = tag;
        case (cls)
            0, 1:    begin e.wr = beats; e.rd = beats; end
            2, 3:    begin e.wr = beats; e.rd = 1;     end
            default: begin e.wr = len;   e.rd = len;   end
        endcase
        sb_q.push_back(e);
        @(negedge clk);
        start    = 1'b1;
        src_addr = AW'(s);
        dst_addr = AW'(d);
        len_m1   = LW'(len - 1);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9", "done single pulse",
            int'({done, busy}), 0);
    endtask

    initial begin
        for (int a = 0; a < MSZ; a++) mem[a] = 8'(a * 7 + 3);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_wr_en && !mem_rd_en, "R11", "reset idle",
            int'({busy, done, mem_wr_en, mem_rd_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_wr_en, "R11", "idle after reset", int'({busy, mem_wr_en}), 0);

        run_move(100, 300,   5, 0, "R6");
        run_move( 40, 200,  16, 0, "R6");
        run_move( 10, 500,  17, 1, "R7");
        run_move(600, 597, 256, 1, "R10");
        run_move( 50,  51,  40, 2, "R2");
        run_move(120, 128, 100, 3, "R3");
        run_move(300, 303,  20, 4, "R4");
        run_move(700, 701,   1, 0, "R1");
        run_move(710, 718,   8, 0, "R1");
        run_move(730, 738,   9, 3, "R3");
        run_move(800, 800,  30, 1, "R1");
        run_move(900, 910,   1, 0, "R10");
        run_move( 20,  21, 256, 2, "R2");
        run_move(400, 405,  33, 4, "R4");

        repeat (2) @(negedge clk);
        chk(sb_q.size() == 0, "R9", "pending scoreboard items", sb_q.size(), 0);
        finish_run();
    end
endmodule